// File: doc/BRIEF.md
# Duty-Cycle Calibration Sequencer

This block is the digital controller of a duty-cycle corrector. It is synchronous and time-driven, and it sits in front of a clock frequency doubler. After a start strobe it runs four stages in order:

1. It measures the high-phase width and the low-phase width of the incoming clock once. If the high phase is the longer one, it selects the inverted clock. From then on the high phase is the shorter one, so the correction only ever has to lengthen it.
2. It raises a pre-delay code one step at a time until an external flag reports that the measured pulse edge falls inside the window of the time-to-digital converter.
3. It loops: it takes a high-phase reading and then a low-phase reading, and raises a two-field delay code by one step while the high phase is still shorter.
4. It stops when the two readings agree within a tolerance, and raises `done_o`.

Each converter result arrives as a thermometer word with a valid strobe. Each result is reduced to a population count, so isolated bubbles do not disturb it. When a search runs out of range, the controller raises `err_o` and freezes. The delay cells, the converter taps and the clock gating are outside the block; it only produces their control codes.

Top module: `dcc_cal_ctrl`

## Requirements
- R1: A start strobe clears the polarity, pre-delay, coarse, fine, done and error outputs. It selects the high phase (`meas_low_o`=0). All of this is visible one cycle later, and the polarity stage begins.
- R2: A converter word is used only in a cycle with `tdc_valid_i`=1. Its value is the number of ones in it, wherever they sit. With the strobe low, no output changes.
- R3: In the polarity stage, the first accepted word is the high count and the second is the low count. `pol_inv_o` becomes 1 (inverted clock) exactly when the high count exceeds the low count.
- R4: In the window stage, each accepted word with `win_ok_i`=0 raises `pre_dly_o` by one. An accepted word with `win_ok_i`=1 keeps the code and begins width comparison. No delay step happens before that.
- R5: If an accepted word has `win_ok_i`=0 while `pre_dly_o` is all ones, `err_o` is set and the sequence stops.
- R6: `meas_low_o` is 0 while a high-phase word is awaited and 1 while a low-phase word is awaited. It changes only on an accepted word.
- R7: After each low-phase word in the comparison loop, if high count + TOL < low count, the 7-bit code {`coarse_o`,`fine_o`} rises by exactly one. Fine wraps from 15 to 0 and carries into coarse.
- R8: After a low-phase word with high count + TOL >= low count, `done_o` is set. All codes then hold until the next start.
- R9: If the shortfall persists while the code is at its maximum (coarse 7, fine 15), `err_o` is set and the code holds.
- R10: `done_o` and `err_o` are never both 1. After either is set, further words change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Restart strobe for the whole calibration |
| tdc_word_i | input | TAPS (20) | Thermometer result from the converter |
| tdc_valid_i | input | 1 | Qualifies `tdc_word_i` |
| win_ok_i | input | 1 | Edge lies inside the converter window |
| pol_inv_o | output | 1 | 1 selects the inverted input clock |
| pre_dly_o | output | PRE_W (5) | Converter pre-delay code |
| meas_low_o | output | 1 | 0 measure high phase, 1 measure low phase |
| coarse_o | output | COARSE_W (3) | Coarse delay count |
| fine_o | output | FINE_W (4) | Fine delay count |
| done_o | output | 1 | Calibration settled |
| err_o | output | 1 | A search ran out of range |

## Verification
Every result of the block is a register that loads on the edge that accepts a valid word or a start strobe. The bench changes inputs on the falling edge and holds each strobe for one cycle. It then reads the polarity, codes, phase select and flags at the next falling edge, half a cycle after the loading edge.

A behavioural plant in the bench turns the current codes into thermometer words. It sweeps the duty split, loop gain, window position and bubble pattern. The final codes are predicted arithmetically and compared once each run has finished. Idle cycles with the strobe low and junk on the word input come between accepted words; there the bench checks that nothing moved.

// File: rtl/dcc_cal_pkg.sv
package dcc_cal_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_POL_HI  = 3'd1,
      ST_POL_LO  = 3'd2,
      ST_WINDOW  = 3'd3,
      ST_CMP_HI  = 3'd4,
      ST_CMP_LO  = 3'd5,
      ST_HOLD    = 3'd6
   } cal_state_t;

   function automatic logic phase_is_low(cal_state_t s);
      return (s == ST_POL_LO) || (s == ST_CMP_LO);
   endfunction

endpackage

// File: rtl/dcc_ones_count.sv
module dcc_ones_count #(
   parameter int TAPS  = 20,
   parameter int CNT_W = $clog2(TAPS + 1)
) (
   input  logic [TAPS-1:0]  word_i,
   output logic [CNT_W-1:0] count_o
);

   localparam int HALF = TAPS / 2;

   generate
      if (TAPS > 8) begin : g_split
         logic [CNT_W-1:0] lo_sum, hi_sum;
         always_comb begin
            lo_sum = '0;
            for (int i = 0; i < HALF; i++)
               lo_sum = lo_sum + CNT_W'(word_i[i]);
         end
         always_comb begin
            hi_sum = '0;
            for (int i = HALF; i < TAPS; i++)
               hi_sum = hi_sum + CNT_W'(word_i[i]);
         end
         assign count_o = lo_sum + hi_sum;
      end else begin : g_chain
         always_comb begin
            count_o = '0;
            for (int i = 0; i < TAPS; i++)
               count_o = count_o + CNT_W'(word_i[i]);
         end
      end
   endgenerate

endmodule

// File: rtl/dcc_width_cmp.sv
module dcc_width_cmp #(
   parameter int W   = 5,
   parameter int TOL = 0
) (
   input  logic [W-1:0] hi_i,
   input  logic [W-1:0] lo_i,
   output logic         hi_longer_o,
   output logic         settled_o
);

   localparam int XW = W + 2;
   localparam logic [XW-1:0] TOL_X = XW'(TOL);

   logic [XW-1:0] hi_x, lo_x;

   always_comb begin
      hi_x        = XW'(hi_i) + TOL_X;
      lo_x        = XW'(lo_i);
      hi_longer_o = hi_i > lo_i;
      settled_o   = hi_x >= lo_x;
   end

endmodule

// File: rtl/dcc_sat_counter.sv
module dcc_sat_counter #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] q_o,
   output logic         at_max_o
);

   localparam logic [W-1:0] TOP = {W{1'b1}};

   assign at_max_o = (q_o == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_o <= '0;
      else if (clr_i)
         q_o <= '0;
      else if (inc_i && !at_max_o)
         q_o <= q_o + W'(1);
   end

endmodule

// File: rtl/dcc_cal_ctrl.sv
module dcc_cal_ctrl
   import dcc_cal_pkg::*;
#(
   parameter int TAPS     = 20,
   parameter int PRE_W    = 5,
   parameter int COARSE_W = 3,
   parameter int FINE_W   = 4,
   parameter int TOL      = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [TAPS-1:0]     tdc_word_i,
   input  logic                tdc_valid_i,
   input  logic                win_ok_i,
   output logic                pol_inv_o,
   output logic [PRE_W-1:0]    pre_dly_o,
   output logic                meas_low_o,
   output logic [COARSE_W-1:0] coarse_o,
   output logic [FINE_W-1:0]   fine_o,
   output logic                done_o,
   output logic                err_o
);

   localparam int CNT_W  = $clog2(TAPS + 1);
   localparam int CODE_W = COARSE_W + FINE_W;

   generate
      if (TAPS < 2) begin : g_bad_taps
         $error("dcc_cal_ctrl: TAPS must be at least 2");
      end
      if (TOL < 0 || TOL >= TAPS) begin : g_bad_tol
         $error("dcc_cal_ctrl: TOL must lie in 0..TAPS-1");
      end
      if (PRE_W < 1 || COARSE_W < 1 || FINE_W < 1) begin : g_bad_w
         $error("dcc_cal_ctrl: code widths must be positive");
      end
   endgenerate

   cal_state_t       state_q, state_d;
   logic [CNT_W-1:0] hi_cnt_q, hi_cnt_d;
   logic [CNT_W-1:0] word_cnt;
   logic             pol_q, pol_d;
   logic             done_q, done_d;
   logic             err_q, err_d;
   logic             pre_inc, code_inc;
   logic             pre_max, code_max;
   logic             hi_longer, settled;
   logic [CODE_W-1:0] code;

   dcc_ones_count #(.TAPS(TAPS), .CNT_W(CNT_W)) u_count (
      .word_i  (tdc_word_i),
      .count_o (word_cnt)
   );

   dcc_width_cmp #(.W(CNT_W), .TOL(TOL)) u_cmp (
      .hi_i        (hi_cnt_q),
      .lo_i        (word_cnt),
      .hi_longer_o (hi_longer),
      .settled_o   (settled)
   );

   dcc_sat_counter #(.W(PRE_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (start_i),
      .inc_i    (pre_inc),
      .q_o      (pre_dly_o),
      .at_max_o (pre_max)
   );

   dcc_sat_counter #(.W(CODE_W)) u_code (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (start_i),
      .inc_i    (code_inc),
      .q_o      (code),
      .at_max_o (code_max)
   );

   always_comb begin
      state_d  = state_q;
      hi_cnt_d = hi_cnt_q;
      pol_d    = pol_q;
      done_d   = done_q;
      err_d    = err_q;
      pre_inc  = 1'b0;
      code_inc = 1'b0;
      if (start_i) begin
         state_d  = ST_POL_HI;
         hi_cnt_d = '0;
         pol_d    = 1'b0;
         done_d   = 1'b0;
         err_d    = 1'b0;
      end else if (tdc_valid_i) begin
         unique case (state_q)
            ST_POL_HI: begin
               hi_cnt_d = word_cnt;
               state_d  = ST_POL_LO;
            end
            ST_POL_LO: begin
               pol_d   = hi_longer;
               state_d = ST_WINDOW;
            end
            ST_WINDOW: begin
               if (win_ok_i)
                  state_d = ST_CMP_HI;
               else if (pre_max) begin
                  err_d   = 1'b1;
                  state_d = ST_HOLD;
               end else
                  pre_inc = 1'b1;
            end
            ST_CMP_HI: begin
               hi_cnt_d = word_cnt;
               state_d  = ST_CMP_LO;
            end
            ST_CMP_LO: begin
               if (settled) begin
                  done_d  = 1'b1;
                  state_d = ST_HOLD;
               end else if (code_max) begin
                  err_d   = 1'b1;
                  state_d = ST_HOLD;
               end else begin
                  code_inc = 1'b1;
                  state_d  = ST_CMP_HI;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         hi_cnt_q <= '0;
         pol_q    <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         state_q  <= state_d;
         hi_cnt_q <= hi_cnt_d;
         pol_q    <= pol_d;
         done_q   <= done_d;
         err_q    <= err_d;
      end
   end

   assign pol_inv_o  = pol_q;
   assign meas_low_o = phase_is_low(state_q);
   assign coarse_o   = code[CODE_W-1:FINE_W];
   assign fine_o     = code[FINE_W-1:0];
   assign done_o     = done_q;
   assign err_o      = err_q;

endmodule

// File: rtl/dcc_cal_ctrl_chk.sv
module dcc_cal_ctrl_chk #(
   parameter int PRE_W    = 5,
   parameter int COARSE_W = 3,
   parameter int FINE_W   = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start_i,
   input logic                tdc_valid_i,
   input logic                pol_inv_o,
   input logic [PRE_W-1:0]    pre_dly_o,
   input logic                meas_low_o,
   input logic [COARSE_W-1:0] coarse_o,
   input logic [FINE_W-1:0]   fine_o,
   input logic                done_o,
   input logic                err_o
);

   localparam int CODE_W = COARSE_W + FINE_W;

   logic [CODE_W-1:0] code;
   assign code = {coarse_o, fine_o};

   assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!done_o && !err_o && !pol_inv_o && !meas_low_o &&
                   pre_dly_o == '0 && code == '0));

   assert_idle_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !tdc_valid_i) |=>
         ($stable(code) && $stable(pre_dly_o) && $stable(meas_low_o) &&
          $stable(pol_inv_o) && $stable(done_o) && $stable(err_o)));

   assert_pre_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> (pre_dly_o == $past(pre_dly_o) ||
                    pre_dly_o == $past(pre_dly_o) + PRE_W'(1)));

   assert_code_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> (code == $past(code) || code == $past(code) + CODE_W'(1)));

   assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && $stable(code) && $stable(pol_inv_o) &&
                                $stable(pre_dly_o)));

   assert_err_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !start_i) |=> (err_o && $stable(code) && $stable(pre_dly_o)));

   assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));

endmodule

bind dcc_cal_ctrl dcc_cal_ctrl_chk #(
   .PRE_W(PRE_W), .COARSE_W(COARSE_W), .FINE_W(FINE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .tdc_valid_i (tdc_valid_i),
   .pol_inv_o   (pol_inv_o),
   .pre_dly_o   (pre_dly_o),
   .meas_low_o  (meas_low_o),
   .coarse_o    (coarse_o),
   .fine_o      (fine_o),
   .done_o      (done_o),
   .err_o       (err_o)
);

// File: tb/dcc_cal_ctrl_test.sv
module dcc_cal_ctrl_test;

   localparam int TAPS = 20;
   localparam int TOL  = 0;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0;
   logic [TAPS-1:0] tdc_word_i = '0;
   logic            tdc_valid_i = 1'b0;
   logic            win_ok_i = 1'b0;
   logic            pol_inv_o;
   logic [4:0]      pre_dly_o;
   logic            meas_low_o;
   logic [2:0]      coarse_o;
   logic [3:0]      fine_o;
   logic            done_o;
   logic            err_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dcc_cal_ctrl #(.TAPS(TAPS), .TOL(TOL)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .tdc_word_i(tdc_word_i), .tdc_valid_i(tdc_valid_i), .win_ok_i(win_ok_i),
      .pol_inv_o(pol_inv_o), .pre_dly_o(pre_dly_o), .meas_low_o(meas_low_o),
      .coarse_o(coarse_o), .fine_o(fine_o), .done_o(done_o), .err_o(err_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [TAPS-1:0] therm(input int n, input bit bub);
      logic [TAPS-1:0] w = '0;
      for (int i = 0; i < n; i++) w[i] = 1'b1;
      if (bub && n >= 1 && n < TAPS) begin
         w[n / 2] = 1'b0;
         w[n]     = 1'b1;
      end
      return w;
   endfunction

   function automatic int phase_cnt(input int h, input int l, input bit inv,
                                    input int k, input int gs, input bit low);
      int hp = inv ? l : h;
      int lp = inv ? h : l;
      int sh = k >> gs;
      int hi = (hp + sh > TAPS) ? TAPS : hp + sh;
      int lo = (lp - sh < 0) ? 0 : lp - sh;
      return low ? lo : hi;
   endfunction

   task automatic run_case(input int h, input int gs, input int pn, input bit bub);
      int  l = TAPS - h;
      bit  exp_inv = (h > l);
      int  exp_pre, exp_k;
      bit  exp_done, exp_err;
      bit  quiet_ok = 1'b1;
      bit  first = 1'b1;
      int  k_now;
      logic m_prev;
      logic [6:0] code_prev;

      if (pn > 31) begin
         exp_pre = 31; exp_k = 0; exp_done = 0; exp_err = 1;
      end else begin
         exp_pre = pn; exp_k = 127; exp_done = 0; exp_err = 1;
         for (int k = 0; k < 128; k++) begin
            if (phase_cnt(h, l, exp_inv, k, gs, 0) + TOL >=
                phase_cnt(h, l, exp_inv, k, gs, 1)) begin
               exp_k = k; exp_done = 1; exp_err = 0;
               break;
            end
         end
      end

      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      // R1: cleared state one cycle after the strobe
      check(!done_o && !err_o && !pol_inv_o && pre_dly_o == 0 &&
            coarse_o == 0 && fine_o == 0 && !meas_low_o,
            "R1 start clears", {done_o, err_o, pol_inv_o, meas_low_o}, 0);

      for (int it = 0; it < 400; it++) begin
         k_now = {coarse_o, fine_o};
         tdc_word_i  = therm(phase_cnt(h, l, pol_inv_o, k_now, gs, meas_low_o), bub);
         win_ok_i    = (int'(pre_dly_o) >= pn);
         tdc_valid_i = 1'b1;
         m_prev      = meas_low_o;
         @(negedge clk);
         tdc_valid_i = 1'b0;
         tdc_word_i  = '1;
         win_ok_i    = 1'b1;
         if (first) begin
            // R6: first accepted (high) word moves selection to low phase
            check(m_prev == 1'b0 && meas_low_o == 1'b1, "R6 phase select",
                  meas_low_o, 1);
            first = 1'b0;
         end
         if (done_o || err_o) break;
         code_prev = {coarse_o, fine_o};
         m_prev    = meas_low_o;
         @(negedge clk);
         if ({coarse_o, fine_o} != code_prev || meas_low_o != m_prev)
            quiet_ok = 1'b0;
      end

      check(quiet_ok, "R2 strobe-low cycles ignored", quiet_ok, 1);
      check(pol_inv_o == exp_inv, "R3 polarity", pol_inv_o, exp_inv);
      check(int'(pre_dly_o) == exp_pre, "R4/R5 pre-delay", pre_dly_o, exp_pre);
      check(done_o == exp_done, "R8 done", done_o, exp_done);
      check(err_o == exp_err, "R9 error", err_o, exp_err);
      check(int'(coarse_o) == (exp_k >> 4), "R7 coarse", coarse_o, exp_k >> 4);
      check(int'(fine_o) == (exp_k & 15), "R7 fine", fine_o, exp_k & 15);

      code_prev = {coarse_o, fine_o};
      for (int j = 0; j < 3; j++) begin
         @(negedge clk);
         tdc_word_i  = therm(j * 7, 1'b0);
         win_ok_i    = j[0];
         tdc_valid_i = 1'b1;
         @(negedge clk);
         tdc_valid_i = 1'b0;
      end
      // R10: finished state holds under further words
      check({coarse_o, fine_o} == code_prev && done_o == exp_done && err_o == exp_err
            && !(done_o && err_o), "R10 hold after finish",
            {coarse_o, fine_o}, code_prev);
   endtask

   initial begin
      wait (cyc == 190000);
      fails++;
      checks++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!done_o && !err_o && !pol_inv_o && !meas_low_o && pre_dly_o == 0 &&
            coarse_o == 0 && fine_o == 0, "R1 reset state", done_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int gs = 2; gs <= 4; gs++)
         for (int h = 0; h <= TAPS; h++)
            run_case(h, gs, h % 5, h[0]);
      run_case(4, 2, 32, 1'b0);
      run_case(17, 3, 32, 1'b1);
      run_case(10, 2, 31, 1'b0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule